// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers for a workstation I/O companion device. It holds a configuration register, a diagnostic byte, a modem control byte, two auxiliary registers, a system control register and a 16-bit LED register. Each register has its own select line. A write strobe stores the write data into the selected register. The read data is a combinational mux that depends on the selects and the word offset.

Several registers have side effects. The power-fail input is latched into a status bit only while its interrupt enable is set, and software can clear that status. One auxiliary bit fires a single-cycle floppy terminal-count pulse and is never stored. A reset command on the system control register sets a reset-status flag and requests a system reset. That flag survives the system reset it triggers. A separate power-on reset, asynchronous and active-low, clears every register. The synchronous system reset clears only the configuration, auxiliary and modem registers.

Top module: `aux_sysctl`

## Requirements
- R1: `irq` is high exactly when configuration bit 3 (power-fail interrupt enable) and aux2 bit 5 (power-fail status) are both set.
- R2: On a clock where `pwr_fail` differs from its value on the previous clock, aux2 bit 5 becomes `pwr_fail` AND the configuration bit 3 value held before that edge. Between such changes the bit holds its value.
- R3: An aux2 write stores written bits 0 and 1 and keeps the current bit 5. If written bit 1 (clear) is 1, only written bit 0 is stored. A `pwr_fail` change on the same edge still updates bit 5 as in R2, and the R2 update wins.
- R4: `pwr_off_req` equals the stored aux2 bit 0.
- R5: An aux1 write with data bit 1 set drives `fd_tc` high for exactly the one cycle after the write edge. Aux1 stores the written byte with bit 1 forced to 0.
- R6: A system control write at offset 0 with data bit 0 set stores 0x02 and drives `sys_rst_req` high for the one following cycle. Writes with bit 0 clear, and writes at any nonzero offset, change nothing. Nonzero offsets read as 0.
- R7: While `sys_reset` is high, configuration, aux1, aux2 and modem are cleared and all bus writes are ignored. Diagnostic, system control and LED keep their values.
- R8: `por_n` low clears all registers, and `irq`, `fd_tc`, `pwr_off_req` and `sys_rst_req` go low.
- R9: Diagnostic and modem are plain 8-bit storage. The LED register is 16 bits wide and is written and read only at offset 0. Writes at other offsets are ignored, and reads there return 0.
- R10: Select bit map: 0 configuration, 1 diagnostic, 2 modem, 3 aux1, 4 aux2, 5 system control, 6 LED. Reads have no side effects. They return the selected value zero-extended to 32 bits, and 0 when no select is active.
- R11: Clearing configuration bit 3 drops `irq` on the next cycle and leaves aux2 bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low, released synchronously |
| sys_reset | input | 1 | Synchronous system reset, active-high |
| sel | input | 7 | Per-register selects, at most one high |
| addr | input | 2 | Word offset within the selected register |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data, zero-extended |
| pwr_fail | input | 1 | Power-fail indication |
| irq | output | 1 | Power-fail interrupt |
| fd_tc | output | 1 | Floppy terminal-count pulse |
| pwr_off_req | output | 1 | Power-off request |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: 8-bit control registers, a 16-bit LED register, a 32-bit read bus and a 2-bit word offset. The 2-bit offset reaches the nonzero offsets of the system control and LED registers. The 16-bit write path reaches the upper LED byte. Directed sequences cover three corner cases: latching with the enable on and off, a clear that lands on the same edge as a power-fail change, and survival of the reset-status flag across a system reset. A long random phase mixes writes, offsets, power-fail changes and system resets against the cycle model.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NUM_SEL  = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_AUX1 = 3;
  localparam int SEL_AUX2 = 4;
  localparam int SEL_SYS  = 5;
  localparam int SEL_LED  = 6;

  localparam int CFG_PFEN_BIT = 3;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int AUX1_TC_BIT  = 1;
  localparam int SYS_CMD_BIT  = 0;
  localparam int SYS_STAT_BIT = 1;
endpackage

// File: rtl/aux_plain_reg.sv
module aux_plain_reg #(
  parameter int W        = 8,
  parameter bit SOFT_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         sys_reset,
  input  logic         we,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = d_in;
    if (SOFT_CLR && sys_reset) q_d = '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q <= '0;
    else        q <= q_d;
  end

  generate
    if (SOFT_CLR) begin : g_clr
      a_r7_soft_clear: assert property (@(posedge clk) disable iff (!por_n)
        sys_reset |=> (q == '0));
    end else begin : g_keep
      a_r7_survives: assert property (@(posedge clk) disable iff (!por_n)
        sys_reset |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/aux_power_unit.sv
module aux_power_unit
  import aux_sysctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         sys_reset,
  input  logic         cfg_we,
  input  logic         aux2_we,
  input  logic [W-1:0] d_in,
  input  logic         pwr_fail,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] aux2_q,
  output logic         irq,
  output logic         pwr_off
);
  logic         pf_q;
  logic         pf_evt;
  logic [W-1:0] cfg_d;
  logic [W-1:0] aux2_d;
  logic [W-1:0] aux2_wr;

  assign pf_evt = pwr_fail ^ pf_q;

  always_comb begin
    aux2_wr = '0;
    aux2_wr[AUX2_OFF_BIT] = d_in[AUX2_OFF_BIT];
    if (!d_in[AUX2_CLR_BIT]) aux2_wr[AUX2_PF_BIT] = aux2_q[AUX2_PF_BIT];
  end

  always_comb begin
    cfg_d  = cfg_q;
    aux2_d = aux2_q;
    if (sys_reset) begin
      cfg_d  = '0;
      aux2_d = '0;
    end else begin
      if (cfg_we)  cfg_d  = d_in;
      if (aux2_we) aux2_d = aux2_wr;
      if (pf_evt)  aux2_d[AUX2_PF_BIT] = pwr_fail & cfg_q[CFG_PFEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pf_q   <= 1'b0;
      cfg_q  <= '0;
      aux2_q <= '0;
    end else begin
      pf_q   <= pwr_fail;
      cfg_q  <= cfg_d;
      aux2_q <= aux2_d;
    end
  end

  assign irq     = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PFEN_BIT];
  assign pwr_off = aux2_q[AUX2_OFF_BIT];

  a_r2_latch_enabled: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(pwr_fail) && cfg_q[CFG_PFEN_BIT] && !sys_reset) |=> aux2_q[AUX2_PF_BIT]);

  a_r2_block_disabled: assert property (@(posedge clk) disable iff (!por_n)
    (pf_evt && !cfg_q[CFG_PFEN_BIT]) |=> !aux2_q[AUX2_PF_BIT]);

  a_r3_clear_keeps_off: assert property (@(posedge clk) disable iff (!por_n)
    (aux2_we && d_in[AUX2_CLR_BIT] && !sys_reset && !pf_evt)
      |=> (aux2_q[W-1:1] == '0) && (aux2_q[0] == $past(d_in[0])));

  a_r11_disable_keeps_status: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_we && !d_in[CFG_PFEN_BIT] && !aux2_we && !pf_evt && !sys_reset)
      |=> !irq && (aux2_q[AUX2_PF_BIT] == $past(aux2_q[AUX2_PF_BIT])));
endmodule

// File: rtl/aux_cmd_unit.sv
module aux_cmd_unit
  import aux_sysctl_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_reset,
  input  logic          aux1_we,
  input  logic          sys_we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  d_in,
  output logic [W-1:0]  aux1_q,
  output logic [W-1:0]  sys_q,
  output logic          tc_pulse,
  output logic          rst_req
);
  logic [W-1:0] aux1_d;
  logic [W-1:0] sys_d;
  logic         tc_d;
  logic         rr_d;
  logic         sys_hit;

  assign sys_hit = sys_we && (addr == '0) && d_in[SYS_CMD_BIT];

  always_comb begin
    aux1_d = aux1_q;
    tc_d   = 1'b0;
    if (sys_reset) begin
      aux1_d = '0;
    end else if (aux1_we) begin
      aux1_d = d_in;
      aux1_d[AUX1_TC_BIT] = 1'b0;
      tc_d   = d_in[AUX1_TC_BIT];
    end
  end

  always_comb begin
    sys_d = sys_q;
    rr_d  = 1'b0;
    if (sys_hit) begin
      sys_d = '0;
      sys_d[SYS_STAT_BIT] = 1'b1;
      rr_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      aux1_q   <= '0;
      sys_q    <= '0;
      tc_pulse <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      aux1_q   <= aux1_d;
      sys_q    <= sys_d;
      tc_pulse <= tc_d;
      rst_req  <= rr_d;
    end
  end

  a_r5_tc_fires: assert property (@(posedge clk) disable iff (!por_n)
    (aux1_we && d_in[AUX1_TC_BIT] && !sys_reset) |=> (tc_pulse && !aux1_q[AUX1_TC_BIT]));

  a_r6_offset_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (sys_we && (addr != '0)) |=> ($stable(sys_q) && !rst_req));

  a_r6_req_with_status: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> sys_q[SYS_STAT_BIT]);
endmodule

// File: rtl/aux_sysctl.sv
module aux_sysctl
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int REG_W  = 8,
  parameter int LED_W  = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_reset,
  input  logic [NUM_SEL-1:0] sel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [LED_W-1:0]   wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               pwr_fail,
  output logic               irq,
  output logic               fd_tc,
  output logic               pwr_off_req,
  output logic               sys_rst_req
);
  localparam int BYTE_LO = 0;

  logic [NUM_SEL-1:0] we;
  logic [REG_W-1:0]   wbyte;
  logic               at_zero;
  logic [REG_W-1:0]   cfg_q, diag_q, mdm_q, aux1_q, aux2_q, sys_q;
  logic [LED_W-1:0]   led_q;

  assign wbyte   = wdata[BYTE_LO +: REG_W];
  assign at_zero = (addr == '0);

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_we
      assign we[i] = wr_en & sel[i] & ~sys_reset;
    end
  endgenerate

  aux_plain_reg #(.W(REG_W), .SOFT_CLR(1'b0)) u_diag (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .we(we[SEL_DIAG]), .d_in(wbyte), .q(diag_q));

  aux_plain_reg #(.W(REG_W), .SOFT_CLR(1'b1)) u_mdm (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .we(we[SEL_MDM]), .d_in(wbyte), .q(mdm_q));

  aux_plain_reg #(.W(LED_W), .SOFT_CLR(1'b0)) u_led (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .we(we[SEL_LED] & at_zero), .d_in(wdata), .q(led_q));

  aux_power_unit #(.W(REG_W)) u_pwr (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .cfg_we(we[SEL_CFG]), .aux2_we(we[SEL_AUX2]), .d_in(wbyte),
    .pwr_fail(pwr_fail), .cfg_q(cfg_q), .aux2_q(aux2_q),
    .irq(irq), .pwr_off(pwr_off_req));

  aux_cmd_unit #(.W(REG_W), .AW(ADDR_W)) u_cmd (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset),
    .aux1_we(we[SEL_AUX1]), .sys_we(we[SEL_SYS]), .addr(addr), .d_in(wbyte),
    .aux1_q(aux1_q), .sys_q(sys_q), .tc_pulse(fd_tc), .rst_req(sys_rst_req));

  always_comb begin
    rdata = '0;
    if (sel[SEL_CFG])             rdata = rdata | DATA_W'(cfg_q);
    if (sel[SEL_DIAG])            rdata = rdata | DATA_W'(diag_q);
    if (sel[SEL_MDM])             rdata = rdata | DATA_W'(mdm_q);
    if (sel[SEL_AUX1])            rdata = rdata | DATA_W'(aux1_q);
    if (sel[SEL_AUX2])            rdata = rdata | DATA_W'(aux2_q);
    if (sel[SEL_SYS] && at_zero)  rdata = rdata | DATA_W'(sys_q);
    if (sel[SEL_LED] && at_zero)  rdata = rdata | DATA_W'(led_q);
  end

  a_r10_one_select: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(sel));

  a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
    (sel == '0) |-> (rdata == '0));

  a_r9_led_offset: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && sel[SEL_LED] && !at_zero) |=> $stable(led_q));

  a_r7_blocks_writes: assert property (@(posedge clk) disable iff (!por_n)
    sys_reset |=> (!fd_tc && !sys_rst_req));
endmodule

// File: tb/test_aux_sysctl.sv
`timescale 1ns/1ps
module test_aux_sysctl;
  localparam int NS = 7;
  localparam int AW = 2;
  localparam int DW = 32;
  localparam int WW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          por_n, sys_reset, wr_en, pwr_fail;
  logic [NS-1:0] sel;
  logic [AW-1:0] addr;
  logic [WW-1:0] wdata;
  wire  [DW-1:0] rdata;
  wire           irq, fd_tc, pwr_off_req, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  aux_sysctl i_aux_sysctl (
    .clk(clk), .por_n(por_n), .sys_reset(sys_reset), .sel(sel), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .pwr_fail(pwr_fail),
    .irq(irq), .fd_tc(fd_tc), .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req));

  // behavioural reference model
  int m_cfg, m_diag, m_mdm, m_aux1, m_aux2, m_sys, m_led;
  bit m_tc, m_rr, m_pf;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux1 = 0; m_aux2 = 0; m_sys = 0; m_led = 0;
      m_tc = 0; m_rr = 0; m_pf = 0;
    end else begin : upd
      bit evt;
      int old_cfg;
      int v;
      evt = (pwr_fail != m_pf);
      m_pf = pwr_fail;
      old_cfg = m_cfg;
      m_tc = 0;
      m_rr = 0;
      if (sys_reset) begin
        m_cfg = 0; m_aux1 = 0; m_aux2 = 0; m_mdm = 0;
      end else begin
        if (wr_en) begin
          if (sel[0]) m_cfg = wdata & 8'hFF;
          if (sel[1]) m_diag = wdata & 8'hFF;
          if (sel[2]) m_mdm = wdata & 8'hFF;
          if (sel[3]) begin m_tc = wdata[1]; m_aux1 = wdata & 8'hFD; end
          if (sel[4]) begin
            v = wdata & 3;
            if (v & 2) v = v & 1;
            else v = v | (m_aux2 & 32'h20);
            m_aux2 = v;
          end
          if (sel[5] && addr == 0 && wdata[0]) begin m_sys = 2; m_rr = 1; end
          if (sel[6] && addr == 0) m_led = wdata;
        end
        if (evt) m_aux2 = (m_aux2 & 32'hDF) | ((pwr_fail && (old_cfg & 8) != 0) ? 32'h20 : 0);
      end
    end
  end

  function automatic int m_read(logic [NS-1:0] s, logic [AW-1:0] a);
    int r = 0;
    if (s[0]) r |= m_cfg;
    if (s[1]) r |= m_diag;
    if (s[2]) r |= m_mdm;
    if (s[3]) r |= m_aux1;
    if (s[4]) r |= m_aux2;
    if (s[5] && a == 0) r |= m_sys;
    if (s[6] && a == 0) r |= m_led;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (cmp_on && por_n) begin
      chk("R1 irq", {31'd0, irq}, {31'd0, ((m_aux2 & 32'h20) != 0) && ((m_cfg & 8) != 0)});
      chk("R4 pwr_off_req", {31'd0, pwr_off_req}, {31'd0, (m_aux2 & 1) != 0});
      chk("R5 fd_tc", {31'd0, fd_tc}, {31'd0, m_tc});
      chk("R6 sys_rst_req", {31'd0, sys_rst_req}, {31'd0, m_rr});
      chk("R10 rdata", rdata, m_read(sel, addr));
    end
  end

  task automatic wr(int s, int a, logic [WW-1:0] d);
    @(negedge clk);
    sel = NS'(1 << s); addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sel = '0; addr = '0;
  endtask

  task automatic rd(int s, int a, logic [31:0] exp, string tag);
    sel = NS'(1 << s); addr = AW'(a);
    #1;
    chk(tag, rdata, exp);
    sel = '0; addr = '0;
  endtask

  task automatic set_pf(bit v);
    @(negedge clk);
    pwr_fail = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    finish_run();
  end

  initial begin
    por_n = 1'b0; sys_reset = 1'b0; wr_en = 1'b0; pwr_fail = 1'b0;
    sel = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int i = 0; i < NS; i++) rd(i, 0, 0, "R8 por clears");
    chk("R8 outputs low", {28'd0, irq, fd_tc, pwr_off_req, sys_rst_req}, 0);
    por_n = 1'b1;
    cmp_on = 1'b1;

    // R2/R1: latch with enable set
    wr(0, 0, 16'h0008);
    set_pf(1'b1);
    rd(4, 0, 32'h20, "R2 status latched");
    chk("R1 irq high", {31'd0, irq}, 1);
    // R11: disable keeps status
    wr(0, 0, 16'h0000);
    chk("R11 irq dropped", {31'd0, irq}, 0);
    rd(4, 0, 32'h20, "R11 status kept");
    wr(0, 0, 16'h0008);
    chk("R1 irq back", {31'd0, irq}, 1);
    // R3/R4: write with clear and off
    wr(4, 0, 16'hFFFF);
    rd(4, 0, 32'h01, "R3 clear keeps off only");
    chk("R4 off asserted", {31'd0, pwr_off_req}, 1);
    chk("R1 irq after clear", {31'd0, irq}, 0);
    wr(4, 0, 16'h0000);
    chk("R4 off released", {31'd0, pwr_off_req}, 0);
    // R2: disabled input change clears and does not latch
    set_pf(1'b0);
    wr(0, 0, 16'h0000);
    set_pf(1'b1);
    rd(4, 0, 32'h00, "R2 no latch disabled");
    set_pf(1'b0);
    // R3: clear coincides with power-fail change, change wins
    wr(0, 0, 16'h0008);
    @(negedge clk);
    sel = NS'(1 << 4); wdata = 16'h0002; wr_en = 1'b1; pwr_fail = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sel = '0;
    rd(4, 0, 32'h20, "R3 change wins over clear");
    // R3: write without clear keeps status
    wr(4, 0, 16'h0001);
    rd(4, 0, 32'h21, "R3 status preserved");
    wr(4, 0, 16'h0002);
    set_pf(1'b0);

    // R5: terminal count
    wr(3, 0, 16'h00FF);
    chk("R5 pulse high", {31'd0, fd_tc}, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, fd_tc}, 0);
    rd(3, 0, 32'hFD, "R5 tc bit not stored");
    wr(3, 0, 16'h0041);
    chk("R5 no pulse", {31'd0, fd_tc}, 0);

    // R6: system control
    wr(5, 0, 16'h00FE);
    rd(5, 0, 32'h00, "R6 bit0 clear ignored");
    wr(5, 1, 16'h0001);
    chk("R6 offset no request", {31'd0, sys_rst_req}, 0);
    rd(5, 0, 32'h00, "R6 offset write ignored");
    wr(5, 0, 16'h0001);
    chk("R6 request pulse", {31'd0, sys_rst_req}, 1);
    rd(5, 0, 32'h02, "R6 status set");
    rd(5, 1, 32'h00, "R6 other offset reads zero");
    @(negedge clk);
    chk("R6 request one cycle", {31'd0, sys_rst_req}, 0);

    // R9: plain storage and LED
    wr(1, 0, 16'h00A5);
    wr(2, 0, 16'h003C);
    wr(6, 0, 16'hBEEF);
    wr(6, 2, 16'h1234);
    rd(1, 0, 32'hA5, "R9 diag");
    rd(2, 0, 32'h3C, "R9 modem");
    rd(6, 0, 32'hBEEF, "R9 led");
    rd(6, 2, 32'h0, "R9 led offset reads zero");
    rd(0, 0, 32'h08, "R10 cfg zero-extended");
    sel = '0; #1; chk("R10 idle read", rdata, 0);

    // R7: system reset
    wr(3, 0, 16'h0080);
    @(negedge clk);
    sys_reset = 1'b1; sel = NS'(1 << 1); wdata = 16'h0077; wr_en = 1'b1;
    @(negedge clk);
    sys_reset = 1'b0; wr_en = 1'b0; sel = '0;
    rd(0, 0, 0, "R7 cfg cleared");
    rd(3, 0, 0, "R7 aux1 cleared");
    rd(4, 0, 0, "R7 aux2 cleared");
    rd(2, 0, 0, "R7 modem cleared");
    rd(1, 0, 32'hA5, "R7 diag kept, write ignored");
    rd(5, 0, 32'h02, "R7 status survives");
    rd(6, 0, 32'hBEEF, "R7 led kept");

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      int s;
      @(negedge clk);
      s = $urandom_range(0, 7);
      sel = (s < NS) ? NS'(1 << s) : '0;
      addr = AW'($urandom_range(0, 3));
      wdata = WW'($urandom);
      wr_en = $urandom_range(0, 1);
      sys_reset = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 7) == 0) pwr_fail = ~pwr_fail;
    end
    @(negedge clk);
    wr_en = 1'b0; sys_reset = 1'b0; sel = '0;

    // R8: power-on reset clears everything
    @(negedge clk);
    por_n = 1'b0;
    #2;
    for (int i = 0; i < NS; i++) rd(i, 0, 0, "R8 por clears all");
    chk("R8 outputs low", {28'd0, irq, fd_tc, pwr_off_req, sys_rst_req}, 0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule